// File: doc/BRIEF.md
# Virtual Channel Input Buffer

This block is the receiving side of one router input port. Several virtual channels share a single physical link. Each virtual channel is its own flit queue. Every arriving flit carries a 2-bit type and a channel number, and the flit is written into the queue of that channel. For each channel the block records whether a packet is still open, meaning its head has arrived but its tail has not. From that record, and from a reuse mode chosen at an input, the block decides whether the channel may be handed to a new packet. It reports that decision and the free slots of each queue to the upstream allocator.

On the read side, a round-robin selector presents one flit per cycle. It picks the flit from the channels that hold data and whose downstream ready input is high. As a result, packets on different channels interleave flit by flit, and a stalled channel never holds up the others. Some flits arrive that cannot be taken: a flit for a full queue, a head for a channel that is not free for reuse, or a flit naming a channel that does not exist. These flits are dropped, and a sticky error flag is raised.

Top module: `vc_input_port`

## Requirements
- R1: The type field is encoded as 00 body, 01 head, 10 tail and 11 single-flit packet (head and tail). An accepted flit is stored in the queue selected by `in_vc`, and each queue returns its flits in arrival order.
- R2: After reset, all queues are empty. Every `free_cnt` field reads DEPTH, every `realloc_ok` bit is 1, and both `out_valid` and `err` are 0.
- R3: Field v of `free_cnt`, at bits [v*CW +: CW], equals DEPTH minus the occupancy of channel v. It changes in the cycle after a write or a read.
- R4: In atomic mode (`mode` 00 or 11), `realloc_ok[v]` is 1 only when channel v has no open packet and its queue is empty.
- R5: In non-atomic mode (`mode` 01), `realloc_ok[v]` is 1 as soon as channel v has no open packet, even if flits are still queued.
- R6: In whole-packet mode (`mode` 10), `realloc_ok[v]` is 1 only when channel v has no open packet and at least MAX_PKT slots are free.
- R7: A head flit opens a packet. A tail or single-flit packet closes it. While a packet is open, the channel is not free for reuse in any mode, even when its queue is empty.
- R8: `out_valid` is 1 whenever some channel holds a flit and has its `dn_ready` bit set. The chosen channel's oldest flit is shown on `out_vc`, `out_type` and `out_data` in the same cycle, and that flit is removed at the next clock edge.
- R9: The selector searches channels starting one above the channel served last, wrapping around. It skips channels that are empty or not ready, so flits of different channels interleave.
- R10: A flit written to a full queue is dropped, and the queue keeps its contents.
- R11: A head flit sent to a channel whose `realloc_ok` bit is 0 is dropped. The channel's queue and its packet state do not change.
- R12: `err` goes high in the cycle after any dropped flit, including a flit with an out-of-range `in_vc`, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_type | input | 2 | Flit type (R1 encoding) |
| in_vc | input | VCW | Target channel |
| in_data | input | DATA_W | Flit payload |
| mode | input | 2 | Reuse rule: 00/11 atomic, 01 non-atomic, 10 whole-packet |
| dn_ready | input | NUM_VC | Per-channel downstream ready |
| out_valid | output | 1 | Flit presented on the read port |
| out_vc | output | VCW | Channel of presented flit |
| out_type | output | 2 | Type of presented flit |
| out_data | output | DATA_W | Payload of presented flit |
| free_cnt | output | NUM_VC*CW | Free slots per channel |
| realloc_ok | output | NUM_VC | Channel may take a new packet |
| err | output | 1 | Sticky drop flag |

## Verification
Most internal faults in this block become visible at the ports within a cycle or two. A wrong occupancy count moves `free_cnt` in the cycle after the write or read. It also changes `realloc_ok` at once in the atomic and whole-packet modes, because that output is combinational in the mode. A lost or stale open-packet bit appears as a channel that is offered for reuse while its packet is still open. It can also appear as a head that is refused, which raises `err` one cycle later. Pointer or arbitration faults show up only when the queues drain, as out-of-order data or an interleave order that breaks the round-robin rule, so the bench drains every queue it fills.

// File: rtl/vc_input_port.sv
module vc_input_port #(
  parameter int NUM_VC  = 2,
  parameter int DEPTH   = 3,
  parameter int DATA_W  = 16,
  parameter int MAX_PKT = 3,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_type,
  input  logic [VCW-1:0]       in_vc,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [1:0]           mode,
  input  logic [NUM_VC-1:0]    dn_ready,
  output logic                 out_valid,
  output logic [VCW-1:0]       out_vc,
  output logic [1:0]           out_type,
  output logic [DATA_W-1:0]    out_data,
  output logic [NUM_VC*CW-1:0] free_cnt,
  output logic [NUM_VC-1:0]    realloc_ok,
  output logic                 err
);
  localparam int FW = DATA_W + 2;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FW-1:0]     mem [NUM_VC][DEPTH];
  logic [CW-1:0]     cnt [NUM_VC];
  logic [PW-1:0]     wp  [NUM_VC];
  logic [PW-1:0]     rp  [NUM_VC];
  logic [NUM_VC-1:0] open_pkt;
  logic [NUM_VC-1:0] wr_v, rd_v;
  logic [VCW-1:0]    rr, sel;
  logic              in_ok, accept;

  wire in_head = in_type[0];
  wire in_tail = in_type[1];

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      free_cnt[v*CW +: CW] = CW'(DEPTH) - cnt[v];
      case (mode)
        2'b01:   realloc_ok[v] = !open_pkt[v];
        2'b10:   realloc_ok[v] = !open_pkt[v] && (DEPTH - int'(cnt[v]) >= MAX_PKT);
        default: realloc_ok[v] = !open_pkt[v] && (cnt[v] == '0);
      endcase
    end
  end

  always_comb begin
    in_ok = 1'b0;
    for (int v = 0; v < NUM_VC; v++)
      if (int'(in_vc) == v)
        in_ok = (int'(cnt[v]) != DEPTH) && !(in_head && !realloc_ok[v]);
  end

  assign accept = in_valid && in_ok;

  always_comb begin
    out_valid = 1'b0;
    sel = '0;
    for (int k = 0; k < NUM_VC; k++) begin
      automatic int idx = (int'(rr) + k) % NUM_VC;
      if (!out_valid && cnt[idx] != '0 && dn_ready[idx]) begin
        out_valid = 1'b1;
        sel = VCW'(idx);
      end
    end
  end

  assign out_vc = sel;
  assign {out_type, out_data} = mem[sel][rp[sel]];

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      wr_v[v] = accept && (int'(in_vc) == v);
      rd_v[v] = out_valid && (int'(sel) == v);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VC; v++) begin
        cnt[v] <= '0;
        wp[v]  <= '0;
        rp[v]  <= '0;
      end
      open_pkt <= '0;
      rr       <= '0;
      err      <= 1'b0;
    end else begin
      if (in_valid && !in_ok) err <= 1'b1;
      if (out_valid) rr <= (int'(sel) == NUM_VC - 1) ? '0 : sel + 1'b1;
      for (int v = 0; v < NUM_VC; v++) begin
        if (wr_v[v]) begin
          mem[v][wp[v]] <= {in_type, in_data};
          wp[v] <= (int'(wp[v]) == DEPTH - 1) ? '0 : wp[v] + 1'b1;
          if (in_tail)      open_pkt[v] <= 1'b0;
          else if (in_head) open_pkt[v] <= 1'b1;
        end
        if (rd_v[v])
          rp[v] <= (int'(rp[v]) == DEPTH - 1) ? '0 : rp[v] + 1'b1;
        cnt[v] <= cnt[v] + CW'(wr_v[v]) - CW'(rd_v[v]);
      end
    end
  end
endmodule

// File: rtl/vc_input_port_chk.sv
module vc_input_port_chk #(
  parameter int NUM_VC  = 2,
  parameter int DEPTH   = 3,
  parameter int DATA_W  = 16,
  parameter int MAX_PKT = 3,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           in_type,
  input logic [VCW-1:0]       in_vc,
  input logic [1:0]           mode,
  input logic [NUM_VC-1:0]    dn_ready,
  input logic                 out_valid,
  input logic [VCW-1:0]       out_vc,
  input logic [NUM_VC*CW-1:0] free_cnt,
  input logic [NUM_VC-1:0]    realloc_ok,
  input logic                 err
);
  wire [CW-1:0] out_free = CW'(free_cnt >> (int'(out_vc) * CW));
  wire          in_vc_ok = int'(in_vc) < NUM_VC;
  wire          tgt_ok   = in_vc_ok && realloc_ok[in_vc];

  // R9
  out_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dn_ready[out_vc]);

  // R8
  out_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_free) != DEPTH);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R11
  head_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type[0] && !tgt_ok) |=> err);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    wire [CW-1:0] fv = free_cnt[v*CW +: CW];
    // R4
    atomic_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00 || mode == 2'b11) && realloc_ok[v]) |-> int'(fv) == DEPTH);
    // R6
    whole_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && realloc_ok[v]) |-> int'(fv) >= MAX_PKT);
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && int'(in_vc) == v && fv == '0 && !(out_valid && int'(out_vc) == v))
        |=> (fv == '0 && err));
  end
endmodule

bind vc_input_port vc_input_port_chk #(
  .NUM_VC(NUM_VC), .DEPTH(DEPTH), .DATA_W(DATA_W), .MAX_PKT(MAX_PKT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
  .in_vc(in_vc), .mode(mode), .dn_ready(dn_ready), .out_valid(out_valid),
  .out_vc(out_vc), .free_cnt(free_cnt), .realloc_ok(realloc_ok), .err(err)
);

// File: tb/sim_vc_input_port.sv
`timescale 1ns/1ps
module sim_vc_input_port;
  localparam int NV = 2, DP = 6, DW = 8, MP = 4, CW = 3;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_type = 0, mode = 0;
  logic in_vc = 0;
  logic [DW-1:0] in_data = 0;
  logic [NV-1:0] dn_ready = 0;
  logic out_valid, out_vc, err;
  logic [1:0] out_type;
  logic [DW-1:0] out_data;
  logic [NV*CW-1:0] free_cnt;
  logic [NV-1:0] realloc_ok;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  vc_input_port #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .MAX_PKT(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_vc(in_vc),
    .in_data(in_data), .mode(mode), .dn_ready(dn_ready), .out_valid(out_valid),
    .out_vc(out_vc), .out_type(out_type), .out_data(out_data), .free_cnt(free_cnt),
    .realloc_ok(realloc_ok), .err(err));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fr(input int v);
    return int'(free_cnt[v*CW +: CW]);
  endfunction

  task automatic push(input int vc, input int ty, input int d);
    @(negedge clk);
    in_valid = 1; in_vc = vc[0]; in_type = ty[1:0]; in_data = d[DW-1:0];
    @(negedge clk);
    in_valid = 0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
  endtask

  task automatic see(input string tag, input int vc, input int d);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " vc"}, int'(out_vc), vc);
    chk({tag, " data"}, int'(out_data), d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ord_vc[6] = '{0, 1, 0, 1, 0, 0};
    int ord_d[6]  = '{10, 21, 11, 22, 12, 13};
    do_reset();
    // R2 reset state, every mode
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0]; #1;
      chk("R2 realloc", int'(realloc_ok), 3);
    end
    mode = 0; #1;
    chk("R2 free0", fr(0), DP); chk("R2 free1", fr(1), DP);
    chk("R2 out_valid", int'(out_valid), 0); chk("R2 err", int'(err), 0);

    // R1 R3 R7: head/body/tail into vc0
    push(0, 1, 10);
    chk("R3 free0 after head", fr(0), 5); chk("R3 free1 untouched", fr(1), 6);
    chk("R7 open blocks", int'(realloc_ok[0]), 0);
    push(0, 0, 11); push(0, 2, 12);
    chk("R3 free0 three", fr(0), 3);
    chk("R4 atomic nonempty", int'(realloc_ok[0]), 0);
    mode = 2'b11; #1; chk("R4 mode11 atomic", int'(realloc_ok[0]), 0);
    mode = 2'b01; #1; chk("R5 nonatomic after tail", int'(realloc_ok[0]), 1);
    mode = 2'b10; #1; chk("R6 whole 3<4", int'(realloc_ok[0]), 0);
    chk("R6 whole vc1 empty", int'(realloc_ok[1]), 1);
    mode = 2'b01;
    push(0, 1, 13);
    chk("R5 head accepted on draining vc", fr(0), 2);
    chk("R7 reopened", int'(realloc_ok[0]), 0);
    push(1, 3, 20);
    chk("R7 single-flit closes", int'(realloc_ok[1]), 1);
    mode = 2'b10; #1; chk("R6 whole 5>=4", int'(realloc_ok[1]), 1);
    mode = 2'b01;
    push(1, 1, 21); push(1, 2, 22);
    chk("R3 free1", fr(1), 3); chk("R12 no err yet", int'(err), 0);

    // R8 R9 drain with skip then interleave
    @(negedge clk); dn_ready = 2'b10; #1;
    see("R9 skip not-ready", 1, 20);
    @(negedge clk); dn_ready = 2'b11; #1;
    for (int i = 0; i < 6; i++) begin
      see("R9 interleave", ord_vc[i], ord_d[i]);
      @(negedge clk); #1;
    end
    chk("R8 empty no valid", int'(out_valid), 0);
    chk("R3 free0 drained", fr(0), DP); chk("R3 free1 drained", fr(1), DP);

    // R7 R11 open empty vc refuses head
    mode = 2'b00; dn_ready = 0; #1;
    chk("R7 empty but open", int'(realloc_ok[0]), 0);
    push(0, 1, 77);
    chk("R11 dropped free", fr(0), DP);
    chk("R11 err", int'(err), 1);
    chk("R11 state kept", int'(realloc_ok[0]), 0);
    repeat (3) @(negedge clk); #1;
    chk("R12 sticky", int'(err), 1);

    // R10 full queue drop
    do_reset();
    chk("R2 err cleared", int'(err), 0);
    push(0, 1, 40);
    for (int i = 1; i < DP; i++) push(0, 0, 40 + i);
    chk("R10 full", fr(0), 0); chk("R10 no err while fitting", int'(err), 0);
    push(0, 0, 99);
    chk("R10 still full", fr(0), 0); chk("R12 err on full", int'(err), 1);
    @(negedge clk); dn_ready = 2'b01; #1;
    for (int i = 0; i < DP; i++) begin
      see("R1 fifo order", 0, 40 + i);
      chk("R1 type", int'(out_type), (i == 0) ? 1 : 0);
      @(negedge clk); #1;
    end
    chk("R10 dropped flit absent", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule